// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small 8-bit controller core sleeps, and how deeply. It has two sleep depths. In the deep stop state the oscillator, the CPU and the timer/watchdog clocks are all gated off. In the lighter wait state only the CPU clock is gated, so the timer keeps counting and can wake the core. The decode stage raises a one-cycle strobe when the core executes a stop or a wait instruction. The block then records the new mode and drives the three enables. In the first cycle of the new mode it pulses a strobe that clears the core's interrupt mask bit, so that a pending interrupt can bring the core back.

The block runs on a free-running always-on clock. This lets an external interrupt end stop mode even though the oscillator enable is low. A static option turns the stop instruction into a no-op. The CPU datapath, the timer, the interrupt vectoring and the oscillator itself lie outside the block.

Top module: `lpm_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. It forces the mode to RUN from any state, with all three enables high and the mask-clear strobe low.
- R2: The mode output is encoded RUN=2'b00, WAIT=2'b01 and STOP=2'b10. The value 2'b11 never appears.
- R3: A stop strobe in RUN, with the disable option low, moves the mode to STOP at the next edge. In STOP the oscillator, CPU clock and timer clock enables are all low.
- R4: In STOP only a reset or an external interrupt (any bit of ext_irq) ends the state. A timer interrupt leaves the mode at STOP.
- R5: While stop_disable is high, a stop strobe has no effect. The mode stays RUN and no mask-clear pulse is issued.
- R6: In WAIT the CPU clock enable is low, while the oscillator and timer clock enables stay high.
- R7: In WAIT either a timer interrupt or an external interrupt ends the state.
- R8: imask_clr is high for exactly the first cycle after a transition from RUN into WAIT or STOP. It is low in every other cycle.
- R9: When stop and wait strobes arrive together in RUN, STOP is entered if stop is allowed. If stop is disabled, WAIT is entered instead.
- R10: Stop and wait strobes that arrive while the mode is WAIT or STOP are ignored.
- R11: A wake event returns the mode to RUN at the next clock edge, and all three enables are high again from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Decoded stop instruction strobe |
| wait_req | input | 1 | Decoded wait instruction strobe |
| ext_irq | input | N_EXT | External interrupt requests |
| tmr_irq | input | 1 | Timer interrupt request |
| stop_disable | input | 1 | Static option that turns stop into a no-op |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Timer and watchdog clock enable |
| imask_clr | output | 1 | One-cycle pulse that clears the interrupt mask bit |
| mode | output | 2 | Current mode (RUN/WAIT/STOP) |

## Verification
The checker enforces several rules on every cycle: the enable pattern each mode must show, that 2'b11 never appears on the mode output, the exits from each sleep state, that a timer interrupt never ends STOP, that a disabled stop produces no pulse, and that the mask-clear strobe is a single cycle tied to leaving RUN. Other behaviour shows only in the bench's scenarios. These scenarios cover strobes ignored while asleep, the fallback to WAIT when a disabled stop coincides with a wait strobe, a reset arriving in the middle of STOP, and long random mixes of strobes and interrupts compared against an independent next-mode model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN  = 2'b00,
    MODE_WAIT = 2'b01,
    MODE_STOP = 2'b10
  } lpm_mode_e;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic tmr;
  } lpm_gates_t;

  // Enable pattern for each mode.
  function automatic lpm_gates_t gates_for(lpm_mode_e m);
    lpm_gates_t g;
    case (m)
      MODE_WAIT: g = '{osc: 1'b1, cpu: 1'b0, tmr: 1'b1};
      MODE_STOP: g = '{osc: 1'b0, cpu: 1'b0, tmr: 1'b0};
      default:   g = '{osc: 1'b1, cpu: 1'b1, tmr: 1'b1};
    endcase
    return g;
  endfunction

  // Wake sources accepted in each sleep depth.
  function automatic logic wake_for(lpm_mode_e m, logic ext_any, logic tmr);
    case (m)
      MODE_WAIT: return ext_any | tmr;
      MODE_STOP: return ext_any;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lpm_entry_arb.sv
module lpm_entry_arb
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_q,
  input  logic      stop_req,
  input  logic      wait_req,
  input  logic      stop_disable,
  output logic      enter_stop,
  output logic      enter_wait,
  output logic      stop_nop
);

  logic in_run;
  logic stop_ok;

  assign in_run     = (mode_q == MODE_RUN);
  assign stop_ok    = stop_req & ~stop_disable;
  assign enter_stop = in_run & stop_ok;
  assign enter_wait = in_run & wait_req & ~stop_ok;
  assign stop_nop   = in_run & stop_req & stop_disable;

endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
  import lpm_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  lpm_mode_e        mode_q,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             tmr_irq,
  output logic             ext_any,
  output logic             wake_evt
);

  logic [N_EXT:0] or_chain;

  assign or_chain[0] = 1'b0;
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext_or
    assign or_chain[i+1] = or_chain[i] | ext_irq[i];
  end

  assign ext_any  = or_chain[N_EXT];
  assign wake_evt = wake_for(mode_q, ext_any, tmr_irq);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk_aon,
  input  logic      rst_n,
  input  logic      enter_stop,
  input  logic      enter_wait,
  input  logic      wake_evt,
  output lpm_mode_e mode_q,
  output logic      imask_clr_q
);

  lpm_mode_e mode_d;
  logic      entering;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_RUN: begin
        if (enter_stop)      mode_d = MODE_STOP;
        else if (enter_wait) mode_d = MODE_WAIT;
      end
      MODE_WAIT, MODE_STOP: begin
        if (wake_evt) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  assign entering = enter_stop | enter_wait;

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_RUN;
      imask_clr_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      imask_clr_q <= entering;
    end
  end

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_q,
  output logic      osc_en,
  output logic      cpu_clk_en,
  output logic      tmr_clk_en
);

  lpm_gates_t g;

  assign g          = gates_for(mode_q);
  assign osc_en     = g.osc;
  assign cpu_clk_en = g.cpu;
  assign tmr_clk_en = g.tmr;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic             clk_aon,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             tmr_irq,
  input  logic             stop_disable,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             tmr_clk_en,
  output logic             imask_clr,
  output logic [1:0]       mode
);

  lpm_mode_e mode_q;
  logic      enter_stop;
  logic      enter_wait;
  logic      stop_nop;
  logic      ext_any;
  logic      wake_evt;

  lpm_entry_arb u_arb (
    .mode_q       (mode_q),
    .stop_req     (stop_req),
    .wait_req     (wait_req),
    .stop_disable (stop_disable),
    .enter_stop   (enter_stop),
    .enter_wait   (enter_wait),
    .stop_nop     (stop_nop)
  );

  lpm_wake_detect #(.N_EXT(N_EXT)) u_wake (
    .mode_q   (mode_q),
    .ext_irq  (ext_irq),
    .tmr_irq  (tmr_irq),
    .ext_any  (ext_any),
    .wake_evt (wake_evt)
  );

  lpm_mode_fsm u_fsm (
    .clk_aon     (clk_aon),
    .rst_n       (rst_n),
    .enter_stop  (enter_stop),
    .enter_wait  (enter_wait),
    .wake_evt    (wake_evt),
    .mode_q      (mode_q),
    .imask_clr_q (imask_clr)
  );

  lpm_clk_gate u_gate (
    .mode_q     (mode_q),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .tmr_clk_en (tmr_clk_en)
  );

  assign mode = mode_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk_aon,
  input logic       rst_n,
  input logic       stop_req,
  input logic       wait_req,
  input logic       tmr_irq,
  input logic       stop_disable,
  input logic       ext_any,
  input logic       stop_nop,
  input logic       osc_en,
  input logic       cpu_clk_en,
  input logic       tmr_clk_en,
  input logic       imask_clr,
  input logic [1:0] mode
);

  localparam logic [1:0] M_RUN  = 2'b00;
  localparam logic [1:0] M_WAIT = 2'b01;
  localparam logic [1:0] M_STOP = 2'b10;

  p_mode_legal_r2: assert property (@(posedge clk_aon) disable iff (!rst_n)
    mode != 2'b11);

  p_stop_gates_r3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_STOP) |-> (!osc_en && !cpu_clk_en && !tmr_clk_en));

  p_stop_entry_r3: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_RUN && stop_req && !stop_disable) |=> (mode == M_STOP));

  p_stop_hold_r4: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_STOP && !ext_any) |=> (mode == M_STOP));

  p_stop_nop_r5: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (stop_nop && !wait_req) |=> (mode == M_RUN && !imask_clr));

  p_wait_gates_r6: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_WAIT) |-> (osc_en && tmr_clk_en && !cpu_clk_en));

  p_wait_exit_r7: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_WAIT && (tmr_irq || ext_any)) |=> (mode == M_RUN));

  p_pulse_single_r8: assert property (@(posedge clk_aon) disable iff (!rst_n)
    imask_clr |=> !imask_clr);

  p_pulse_on_entry_r8: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode != M_RUN && $past(mode) == M_RUN) |-> imask_clr);

  p_pulse_cause_r8: assert property (@(posedge clk_aon) disable iff (!rst_n)
    imask_clr |-> (mode != M_RUN));

  p_stop_exit_r11: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (mode == M_STOP && ext_any) |=> (mode == M_RUN && osc_en && cpu_clk_en && tmr_clk_en));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_aon      (clk_aon),
  .rst_n        (rst_n),
  .stop_req     (stop_req),
  .wait_req     (wait_req),
  .tmr_irq      (tmr_irq),
  .stop_disable (stop_disable),
  .ext_any      (ext_any),
  .stop_nop     (stop_nop),
  .osc_en       (osc_en),
  .cpu_clk_en   (cpu_clk_en),
  .tmr_clk_en   (tmr_clk_en),
  .imask_clr    (imask_clr),
  .mode         (mode)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_EXT      = 2;
  localparam int N_RANDOM   = 3000;
  localparam int WDOG_LIMIT = 50000;

  logic             clk_aon = 1'b0;
  logic             rst_n;
  logic             stop_req, wait_req, tmr_irq, stop_disable;
  logic [N_EXT-1:0] ext_irq;
  logic             osc_en, cpu_clk_en, tmr_clk_en, imask_clr;
  logic [1:0]       mode;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  logic [1:0] exp_mode;
  logic       exp_pulse;

  always #(CLK_PERIOD/2) clk_aon = ~clk_aon;

  lpm_ctrl #(.N_EXT(N_EXT)) dut_i (
    .clk_aon      (clk_aon),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .wait_req     (wait_req),
    .ext_irq      (ext_irq),
    .tmr_irq      (tmr_irq),
    .stop_disable (stop_disable),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .tmr_clk_en   (tmr_clk_en),
    .imask_clr    (imask_clr),
    .mode         (mode)
  );

  // Next mode from current mode and stimulus, written from the requirements.
  function automatic logic [1:0] model_next(logic [1:0] m, logic s, logic w,
                                            logic e, logic t, logic d);
    if (m == 2'b00) begin
      if (s && !d) return 2'b10;
      if (w)       return 2'b01;
      return 2'b00;
    end
    if (m == 2'b01) return (e || t) ? 2'b00 : 2'b01;
    return e ? 2'b00 : 2'b10;
  endfunction

  // Packed {mode, osc, cpu, tmr, pulse}.
  function automatic logic [5:0] model_outs(logic [1:0] m, logic p);
    logic o, c, t;
    o = (m != 2'b10);
    c = (m == 2'b00);
    t = (m != 2'b10);
    return {m, o, c, t, p};
  endfunction

  task automatic check_outs(string req);
    logic [5:0] act, exp;
    act = {mode, osc_en, cpu_clk_en, tmr_clk_en, imask_clr};
    exp = model_outs(exp_mode, exp_pulse);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {mode,osc,cpu,tmr,clr} actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next fall.
  task automatic step(logic s, logic w, logic [N_EXT-1:0] e, logic t, logic d, string req);
    logic [1:0] nm;
    stop_req = s; wait_req = w; ext_irq = e; tmr_irq = t; stop_disable = d;
    nm        = model_next(exp_mode, s, w, |e, t, d);
    exp_pulse = (exp_mode == 2'b00) && (nm != 2'b00);
    exp_mode  = nm;
    @(negedge clk_aon);
    check_outs(req);
  endtask

  initial begin : watchdog
    repeat (WDOG_LIMIT) @(posedge clk_aon);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    stop_req = 0; wait_req = 0; ext_irq = '0; tmr_irq = 0; stop_disable = 0;
    exp_mode = 2'b00; exp_pulse = 1'b0;
    repeat (2) @(negedge clk_aon);
    check_outs("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk_aon);
    check_outs("R1 after release");

    // Wait entry, ignored strobes, timer wake.
    step(0, 1, 2'b00, 0, 0, "R6 R8 wait entry");
    step(0, 0, 2'b00, 0, 0, "R8 no second pulse");
    step(1, 1, 2'b00, 0, 0, "R10 strobes ignored in wait");
    step(0, 0, 2'b00, 1, 0, "R7 R11 timer wakes wait");

    // Stop entry, timer ignored, external wake.
    step(1, 0, 2'b00, 0, 0, "R3 R8 stop entry");
    step(0, 0, 2'b00, 1, 0, "R4 timer ignored in stop");
    step(0, 1, 2'b00, 1, 0, "R10 strobes ignored in stop");
    step(0, 0, 2'b10, 0, 0, "R4 R11 ext wakes stop");

    // Stop disabled.
    step(1, 0, 2'b00, 0, 1, "R5 stop is no-op");
    step(0, 0, 2'b00, 0, 1, "R5 still run");

    // Priority.
    step(1, 1, 2'b00, 0, 0, "R9 stop over wait");
    step(0, 0, 2'b01, 0, 0, "R11 exit stop");
    step(1, 1, 2'b00, 0, 1, "R9 disabled stop falls to wait");
    step(0, 0, 2'b01, 0, 0, "R7 ext wakes wait");

    // Reset in the middle of STOP.
    step(1, 0, 2'b00, 0, 0, "R3 stop before reset");
    stop_req = 0;
    rst_n = 1'b0;
    #1;
    exp_mode = 2'b00; exp_pulse = 1'b0;
    check_outs("R1 async reset from stop");
    @(negedge clk_aon);
    rst_n = 1'b1;
    @(negedge clk_aon);
    check_outs("R1 run after reset");

    // Random mix.
    for (int i = 0; i < N_RANDOM; i++) begin
      logic s, w, t, d;
      logic [N_EXT-1:0] e;
      s = ($urandom_range(0, 5) == 0);
      w = ($urandom_range(0, 5) == 0);
      t = ($urandom_range(0, 7) == 0);
      d = ($urandom_range(0, 3) == 0);
      e = ($urandom_range(0, 9) == 0) ? N_EXT'($urandom) : '0;
      step(s, w, e, t, d, "R2 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule